// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns a single host request into a timed access on a slow external peripheral bus that has a 20-bit address, 8-bit data, two active-low chip selects and active-low write and read strobes. A request carries a direction, an address, write data and a zone index. The block accepts it only while idle. It then steps through a fixed sequence of phases. First it presents the address, and the write data for writes. Next it asserts the chip select of the chosen zone, then opens a long strobe, then releases the strobe, the chip select and finally the address.

Each zone has a static wait-state count and a ready-enable bit. The block snapshots both at acceptance. The strobe lasts a base length plus the zone's wait-state count: 16 clocks for writes and 12 for reads. When ready handling is enabled for the zone, the strobe phase is further stretched until the active-high ready input is sampled high. For reads, the bus value is captured on the edge that releases the read strobe and is returned with a one-cycle done pulse.

The controller is one state machine with six states:
- `SEQ_IDLE`: no access in progress.
- `SEQ_SETUP`: address out, selects high, 1 cycle.
- `SEQ_CS_LEAD`: chip select low, 3 cycles.
- `SEQ_STROBE`: strobe low, for the computed length plus any ready extension.
- `SEQ_RELEASE`: strobe high, chip select still low, 1 cycle.
- `SEQ_TAIL`: selects high, address held, 2 cycles.

Its transitions are:
- IDLE→SETUP on an accepted request.
- SETUP→CS_LEAD always.
- CS_LEAD→STROBE when the lead count ends.
- STROBE→RELEASE when the length has elapsed and ready is satisfied.
- RELEASE→TAIL always.
- TAIL→IDLE when the tail count ends; the address clears to zero on this transition.

Top module: `extbus_seq`

## Requirements
- R1: During and right after reset, both chip selects, the write strobe and the read strobe are high, the address is zero, busy is low, done is low, and the data bus is not driven.
- R2: A request seen with `req_valid` high on a clock edge while idle is accepted on that edge. From the next cycle `busy` is high, `bus_addr` shows the request address, and for a write `bus_data` shows the write data, with both chip selects still high.
- R3: One cycle after the address appears, exactly one chip select goes low: bit z of `bus_cs_n` for zone index z. The other chip select stays high.
- R4: The strobe goes low exactly three cycles after the chip select falls. The strobe is `bus_wr_n` for a write and `bus_rd_n` for a read. The other strobe stays high, and a strobe is never low without a chip select low.
- R5: With ready handling disabled for the zone, the strobe stays low for 16 + W cycles on a write and 12 + W cycles on a read. W is the zone's 4-bit wait-state field, bits [4z+3:4z] of `cfg_wait`.
- R6: With ready handling enabled (bit z of `cfg_rdy_en`), the strobe is released on the first edge at which the base length has elapsed and `bus_rdy` is sampled high. If ready is already high, the width equals the R5 width.
- R7: The chip select rises one cycle after the strobe rises. Two cycles after that, the address returns to zero and `busy` falls in the same cycle.
- R8: Address, chip selects and write data hold steady for the whole strobe-low period.
- R9: A read returns the bus value sampled on the edge that releases the read strobe, with `rd_done` high for exactly the one cycle after that edge. Writes never raise `rd_done`.
- R10: The data bus is driven only for writes, from the first cycle until the chip select is released, and is never driven while the read strobe is low.
- R11: A request presented while busy is ignored: the running access keeps its address and timing, and no extra access follows.
- R12: With ready handling disabled for the zone, a low `bus_rdy` has no effect on the strobe width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Access address |
| req_wdata | input | 8 | Write data |
| req_zone | input | 1 | Zone index selecting chip select and configuration |
| cfg_wait | input | 8 | Per-zone 4-bit wait-state counts, zone z at [4z+3:4z] |
| cfg_rdy_en | input | 2 | Per-zone ready-enable bits |
| busy | output | 1 | High from acceptance until the address returns to zero |
| rd_done | output | 1 | One-cycle pulse with read data |
| rd_data | output | 8 | Captured read data |
| bus_addr | output | 20 | External address bus |
| bus_data | inout | 8 | External bidirectional data bus |
| bus_cs_n | output | 2 | Active-low chip selects, one per zone |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_rdy | input | 1 | Active-high ready from the peripheral |

## Verification
Several properties are checked on every cycle:
- At most one chip select is active, the strobes never overlap, and a strobe is never low without a chip select.
- Acceptance leads to busy, the address is zero whenever the block is idle, and it is frozen under a write strobe.
- The write strobe's release is followed by chip-select release.
- The done pulse lasts one cycle and coincides with a read-strobe rising edge, and the data bus is never driven under a read strobe.

Only the bench's scenarios can show the exact phase lengths: the 1-cycle lead, the 3-cycle lead, the 16/12 + W strobe width, the ready stretch and the 2-cycle tail. They also show the address and data values, the captured read data, and that a low ready without enable, or a request while busy, leaves an access unchanged.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_SETUP,
        SEQ_CS_LEAD,
        SEQ_STROBE,
        SEQ_RELEASE,
        SEQ_TAIL
    } seq_state_e;

    function automatic int unsigned larger_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/extbus_phase_timer.sv
module extbus_phase_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    // Counts cycles spent in the current phase; saturates so long ready waits cannot wrap.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != {CNT_W{1'b1}}) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/extbus_req_hold.sv
module extbus_req_hold #(
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 8,
    parameter int ZONES   = 2,
    parameter int ZONE_W  = 1,
    parameter int WAIT_W  = 4,
    parameter int CNT_W   = 6,
    parameter int WR_BASE = 16,
    parameter int RD_BASE = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    accept,
    input  logic                    finish,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    input  logic [ZONE_W-1:0]       req_zone,
    input  logic [ZONES*WAIT_W-1:0] cfg_wait,
    input  logic [ZONES-1:0]        cfg_rdy_en,
    output logic [ADDR_W-1:0]       addr_q,
    output logic [DATA_W-1:0]       wdata_q,
    output logic [ZONE_W-1:0]       zone_q,
    output logic                    write_q,
    output logic [CNT_W-1:0]        len_q,
    output logic                    rdy_en_q
);
    logic [WAIT_W-1:0] ws_sel;
    logic [CNT_W-1:0]  len_nx;
    logic              rdy_sel;

    always_comb begin
        ws_sel  = cfg_wait[req_zone*WAIT_W +: WAIT_W];
        rdy_sel = cfg_rdy_en[req_zone];
        len_nx  = (req_write ? CNT_W'(WR_BASE) : CNT_W'(RD_BASE)) + CNT_W'(ws_sel);
    end

    // Configuration is snapshotted at acceptance so it cannot shift mid-access.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            zone_q   <= '0;
            write_q  <= 1'b0;
            len_q    <= '0;
            rdy_en_q <= 1'b0;
        end else if (accept) begin
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
            zone_q   <= req_zone;
            write_q  <= req_write;
            len_q    <= len_nx;
            rdy_en_q <= rdy_sel;
        end else if (finish) begin
            addr_q   <= '0;
        end
    end
endmodule

// File: rtl/extbus_rd_capture.sv
module extbus_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output logic              done,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            data <= '0;
        end else begin
            done <= capture;
            if (capture) begin
                data <= bus_in;
            end
        end
    end
endmodule

// File: rtl/extbus_fsm.sv
module extbus_fsm
    import extbus_pkg::*;
#(
    parameter int CNT_W   = 6,
    parameter int CS_LEAD = 3,
    parameter int TAIL    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             rdy_ok,
    input  logic             write_q,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] strobe_len,
    output seq_state_e       state,
    output logic             accept,
    output logic             cnt_clr,
    output logic             leave_strobe,
    output logic             finish,
    output logic             busy,
    output logic             cs_active,
    output logic             strobe_act,
    output logic             data_oe
);
    localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

    seq_state_e state_nx;
    logic       lead_done;
    logic       tail_done;
    logic       len_done;

    always_comb begin
        lead_done = (cnt == CNT_W'(CS_LEAD - 1));
        tail_done = (cnt == CNT_W'(TAIL - 1));
        len_done  = (({1'b0, cnt} + ONE) >= {1'b0, strobe_len});
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE:    if (req_valid)            state_nx = SEQ_SETUP;
            SEQ_SETUP:                             state_nx = SEQ_CS_LEAD;
            SEQ_CS_LEAD: if (lead_done)            state_nx = SEQ_STROBE;
            SEQ_STROBE:  if (len_done && rdy_ok)   state_nx = SEQ_RELEASE;
            SEQ_RELEASE:                           state_nx = SEQ_TAIL;
            SEQ_TAIL:    if (tail_done)            state_nx = SEQ_IDLE;
            default:                               state_nx = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        busy         = 1'b1;
        cs_active    = 1'b0;
        strobe_act   = 1'b0;
        data_oe      = 1'b0;
        accept       = 1'b0;
        leave_strobe = 1'b0;
        finish       = 1'b0;
        unique case (state)
            SEQ_IDLE: begin
                busy   = 1'b0;
                accept = req_valid;
            end
            SEQ_SETUP: begin
                data_oe = write_q;
            end
            SEQ_CS_LEAD: begin
                cs_active = 1'b1;
                data_oe   = write_q;
            end
            SEQ_STROBE: begin
                cs_active    = 1'b1;
                strobe_act   = 1'b1;
                data_oe      = write_q;
                leave_strobe = (state_nx == SEQ_RELEASE);
            end
            SEQ_RELEASE: begin
                cs_active = 1'b1;
                data_oe   = write_q;
            end
            SEQ_TAIL: begin
                finish = (state_nx == SEQ_IDLE);
            end
            default: begin
                busy = 1'b0;
            end
        endcase
        cnt_clr = (state_nx != state);
    end
endmodule

// File: rtl/extbus_seq.sv
module extbus_seq
    import extbus_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 8,
    parameter int ZONES   = 2,
    parameter int WAIT_W  = 4,
    parameter int WR_BASE = 16,
    parameter int RD_BASE = 12,
    parameter int CS_LEAD = 3,
    parameter int TAIL    = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    input  logic [((ZONES > 1) ? $clog2(ZONES) : 1)-1:0] req_zone,
    input  logic [ZONES*WAIT_W-1:0] cfg_wait,
    input  logic [ZONES-1:0]        cfg_rdy_en,
    output logic                    busy,
    output logic                    rd_done,
    output logic [DATA_W-1:0]       rd_data,
    output logic [ADDR_W-1:0]       bus_addr,
    inout  wire  [DATA_W-1:0]       bus_data,
    output logic [ZONES-1:0]        bus_cs_n,
    output logic                    bus_wr_n,
    output logic                    bus_rd_n,
    input  logic                    bus_rdy
);
    localparam int ZONE_W  = (ZONES > 1) ? $clog2(ZONES) : 1;
    localparam int LEN_MAX = larger_of(WR_BASE, RD_BASE) + (1 << WAIT_W);
    localparam int CNT_W   = $clog2(larger_of(LEN_MAX, larger_of(CS_LEAD, TAIL)) + 1);

    seq_state_e        state;
    logic              accept;
    logic              cnt_clr;
    logic              leave_strobe;
    logic              finish;
    logic              cs_active;
    logic              strobe_act;
    logic              data_oe;
    logic              rdy_ok;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  len_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [ZONE_W-1:0] zone_q;
    logic              write_q;
    logic              rdy_en_q;

    extbus_req_hold #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .ZONES   (ZONES),
        .ZONE_W  (ZONE_W),
        .WAIT_W  (WAIT_W),
        .CNT_W   (CNT_W),
        .WR_BASE (WR_BASE),
        .RD_BASE (RD_BASE)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .finish     (finish),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_zone   (req_zone),
        .cfg_wait   (cfg_wait),
        .cfg_rdy_en (cfg_rdy_en),
        .addr_q     (addr_q),
        .wdata_q    (wdata_q),
        .zone_q     (zone_q),
        .write_q    (write_q),
        .len_q      (len_q),
        .rdy_en_q   (rdy_en_q)
    );

    extbus_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    assign rdy_ok = ~rdy_en_q | bus_rdy;

    extbus_fsm #(
        .CNT_W   (CNT_W),
        .CS_LEAD (CS_LEAD),
        .TAIL    (TAIL)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .rdy_ok       (rdy_ok),
        .write_q      (write_q),
        .cnt          (cnt),
        .strobe_len   (len_q),
        .state        (state),
        .accept       (accept),
        .cnt_clr      (cnt_clr),
        .leave_strobe (leave_strobe),
        .finish       (finish),
        .busy         (busy),
        .cs_active    (cs_active),
        .strobe_act   (strobe_act),
        .data_oe      (data_oe)
    );

    extbus_rd_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (leave_strobe & ~write_q),
        .bus_in  (bus_data),
        .done    (rd_done),
        .data    (rd_data)
    );

    for (genvar z = 0; z < ZONES; z++) begin : g_cs
        assign bus_cs_n[z] = ~(cs_active && (zone_q == ZONE_W'(z)));
    end

    assign bus_addr = addr_q;
    assign bus_wr_n = ~(strobe_act & write_q);
    assign bus_rd_n = ~(strobe_act & ~write_q);
    assign bus_data = data_oe ? wdata_q : {DATA_W{1'bz}};
endmodule

// File: rtl/extbus_seq_chk.sv
module extbus_seq_chk #(
    parameter int ADDR_W = 20,
    parameter int ZONES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              rd_done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [ZONES-1:0]  bus_cs_n,
    input logic              bus_wr_n,
    input logic              bus_rd_n,
    input logic              data_oe
);
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy); // R2

    AST_SINGLE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~bus_cs_n) <= 1); // R3

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_wr_n && !bus_rd_n)); // R4

    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr_n || !bus_rd_n) |-> !(&bus_cs_n)); // R4

    AST_WR_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr_n) |=> (&bus_cs_n)); // R7

    AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_addr == '0)); // R7

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr_n && $past(!bus_wr_n)) |-> $stable(bus_addr)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done); // R9

    AST_DONE_ON_RD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> $rose(bus_rd_n)); // R9

    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !data_oe); // R10
endmodule

bind extbus_seq extbus_seq_chk #(
    .ADDR_W (ADDR_W),
    .ZONES  (ZONES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .rd_done   (rd_done),
    .bus_addr  (bus_addr),
    .bus_cs_n  (bus_cs_n),
    .bus_wr_n  (bus_wr_n),
    .bus_rd_n  (bus_rd_n),
    .data_oe   (data_oe)
);

// File: tb/tb_extbus_seq.sv
module tb_extbus_seq;
    localparam int AW = 20;
    localparam int DW = 8;
    localparam int WW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [0:0]    req_zone = '0;
    logic [2*WW-1:0] cfg_wait = '0;
    logic [1:0]    cfg_rdy_en = '0;
    logic          busy;
    logic          rd_done;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] bus_addr;
    wire  [DW-1:0] bus_data;
    logic [1:0]    bus_cs_n;
    logic          bus_wr_n;
    logic          bus_rd_n;
    logic          bus_rdy = 1'b1;
    logic [DW-1:0] rd_val = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    // Peripheral model: drives the data bus only while the read strobe is low.
    assign bus_data = !bus_rd_n ? rd_val : {DW{1'bz}};

    extbus_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_zone   (req_zone),
        .cfg_wait   (cfg_wait),
        .cfg_rdy_en (cfg_rdy_en),
        .busy       (busy),
        .rd_done    (rd_done),
        .rd_data    (rd_data),
        .bus_addr   (bus_addr),
        .bus_data   (bus_data),
        .bus_cs_n   (bus_cs_n),
        .bus_wr_n   (bus_wr_n),
        .bus_rd_n   (bus_rd_n),
        .bus_rdy    (bus_rdy)
    );

    typedef struct {
        bit            wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        int            zone;
        int            width;
        string         wtag;
    } item_t;

    item_t sb[$];

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Driver: configures the zone, pushes the expected access, issues the request.
    task automatic run_xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input int z, input int ws, input bit ren, input bit rdy0,
                            input int rel_at, input bit poke, input string wtag);
        item_t it;
        @(negedge clk);
        while (busy) @(negedge clk);
        cfg_wait[z*WW +: WW] = WW'(ws);
        cfg_rdy_en[z] = ren;
        bus_rdy = rdy0;
        rd_val = d;
        it.wr = wr; it.addr = a; it.data = d; it.zone = z; it.wtag = wtag;
        it.width = (wr ? 16 : 12) + ws;
        if (ren && !rdy0 && (rel_at + 1 > it.width)) it.width = rel_at + 1;
        sb.push_back(it);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_zone = 1'(z);
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            req_valid = 1'b1; req_write = !wr; req_addr = a ^ {AW{1'b1}}; req_wdata = ~d;
            @(negedge clk);
            req_valid = 1'b0;
        end
        if (ren && !rdy0) begin
            while (wr ? bus_wr_n : bus_rd_n) @(negedge clk);
            for (int j = 0; j < rel_at; j++) @(negedge clk);
            bus_rdy = 1'b1;
        end
        while (busy) @(negedge clk);
    endtask

    // Monitor: pops the expected access and measures every phase at the ports.
    initial begin : monitor
        item_t   it;
        int      n;
        bit      stable_ok;
        bit      data_ok;
        bit      early_done;
        logic [1:0] mask;
        forever begin
            @(negedge clk);
            if (rst_n && busy) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R11 unexpected access", longint'(bus_addr), 0);
                    while (busy) @(negedge clk);
                end else begin
                    it = sb.pop_front();
                    mask = 2'(1 << it.zone);
                    check(bus_addr == it.addr, "R2 address out", longint'(bus_addr), longint'(it.addr));
                    if (it.wr) check(bus_data == it.data, "R2 write data out", longint'(bus_data), longint'(it.data));
                    check(&bus_cs_n, "R2 selects high in setup", longint'(bus_cs_n), 3);
                    n = 0;
                    while (&bus_cs_n) begin @(negedge clk); n++; end
                    check(n == 1, "R3 chip-select lead", n, 1);
                    check(~bus_cs_n == mask, "R3 zone select", longint'(~bus_cs_n), longint'(mask));
                    n = 0;
                    while (it.wr ? bus_wr_n : bus_rd_n) begin @(negedge clk); n++; end
                    check(n == 3, "R4 strobe after select", n, 3);
                    check((it.wr ? bus_rd_n : bus_wr_n) == 1'b1, "R4 other strobe high", 0, 1);
                    n = 0; stable_ok = 1'b1; data_ok = 1'b1; early_done = 1'b0;
                    while (!(it.wr ? bus_wr_n : bus_rd_n)) begin
                        if (bus_addr != it.addr || ~bus_cs_n != mask) stable_ok = 1'b0;
                        if (it.wr && bus_data != it.data) data_ok = 1'b0;
                        if (rd_done) early_done = 1'b1;
                        @(negedge clk); n++;
                    end
                    check(n == it.width, {it.wtag, " strobe width"}, n, it.width);
                    check(stable_ok, "R8 outputs steady under strobe", 0, 1);
                    if (it.wr) check(data_ok, "R10 write data driven", 0, 1);
                    check(!early_done, "R9 no done during strobe", 1, 0);
                    if (it.wr) begin
                        check(rd_done == 1'b0, "R9 no done on write", longint'(rd_done), 0);
                    end else begin
                        check(rd_done == 1'b1, "R9 done pulse", longint'(rd_done), 1);
                        check(rd_data == it.data, "R9 read data", longint'(rd_data), longint'(it.data));
                    end
                    n = 0;
                    while (!(&bus_cs_n)) begin @(negedge clk); n++; end
                    check(n == 1, "R7 select release", n, 1);
                    check(rd_done == 1'b0, "R9 single-cycle done", longint'(rd_done), 0);
                    check(bus_addr == it.addr, "R7 address held in tail", longint'(bus_addr), longint'(it.addr));
                    n = 0;
                    while (busy) begin @(negedge clk); n++; end
                    check(n == 2, "R7 tail length", n, 2);
                    check(bus_addr == '0, "R7 address zero", longint'(bus_addr), 0);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(bus_cs_n == 2'b11 && bus_wr_n && bus_rd_n, "R1 strobes high in reset", longint'({bus_cs_n, bus_wr_n, bus_rd_n}), 15);
        check(bus_addr == '0 && !busy && !rd_done, "R1 address and busy clear", longint'(bus_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && bus_cs_n == 2'b11 && bus_addr == '0, "R1 idle after reset", longint'(busy), 0);

        run_xfer(1'b1, 20'h12345, 8'h3C, 0, 0,  1'b0, 1'b1, 0,  1'b0, "R5");
        run_xfer(1'b1, 20'hABCDE, 8'hC3, 1, 5,  1'b0, 1'b1, 0,  1'b0, "R5");
        run_xfer(1'b0, 20'h00F0F, 8'hA5, 0, 0,  1'b0, 1'b1, 0,  1'b0, "R5");
        run_xfer(1'b0, 20'hFFFFF, 8'h5A, 1, 15, 1'b0, 1'b1, 0,  1'b0, "R5");
        run_xfer(1'b1, 20'h54321, 8'h99, 1, 5,  1'b1, 1'b0, 25, 1'b0, "R6");
        run_xfer(1'b0, 20'h0BEEF, 8'h42, 1, 5,  1'b1, 1'b1, 0,  1'b0, "R6");
        run_xfer(1'b0, 20'h70001, 8'h17, 0, 3,  1'b1, 1'b0, 20, 1'b0, "R6");
        run_xfer(1'b1, 20'h0C0DE, 8'h81, 0, 2,  1'b0, 1'b0, 0,  1'b0, "R12");
        run_xfer(1'b1, 20'h2468A, 8'h6E, 0, 1,  1'b0, 1'b1, 0,  1'b1, "R11");

        repeat (6) @(negedge clk);
        check(!busy && bus_addr == '0, "R11 no access after ignored request", longint'(bus_addr), 0);
        check(sb.size() == 0, "R2 all accesses seen", sb.size(), 0);
        summary();
        $finish;
    end
endmodule